// File: doc/BRIEF.md
# I2C Slave Receive Engine

This block is the receive side of an I2C target. It watches the two bus lines, waits for a START condition and shifts in the first byte. It compares the upper seven bits of that byte with a programmable own address. When the address matches, the engine accepts the data bytes that follow into a single holding register, which the CPU reads through simple strobes. The engine acknowledges a byte by pulling SDA low through an output-enable pin during the ninth clock.

Flow control is strict. The engine acknowledges a byte only when the holding register is free and the overflow flag is clear. A byte that arrives while the register still holds unread data sets the sticky overflow flag and is not acknowledged. A CPU read of the holding register does not clear the buffer-full flag at once. The release is recorded and takes effect at the next acknowledge decision, so the flag can never show a stale value as empty in the middle of a byte.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, sda_oe, buf_full, ovf, irq, rw_bit, start_seen and stop_seen are all 0.
- R2: SDA falling while SCL is high is a START: start_seen is set, stop_seen is cleared, and an address byte is expected. SDA rising while SCL is high is a STOP: stop_seen is set, start_seen is cleared, and the engine ignores bytes until the next START.
- R3: Bits are sampled on SCL rising edges, MSB first. At the falling edge of the 8th SCL pulse, bits 7:1 of an address byte are compared with own_addr. On a match with the buffer free and ovf clear, the whole byte is copied into buf_data, buf_full is set, and sda_oe is held high until the falling edge of the 9th pulse. rw_bit takes bit 0 of every matched address byte.
- R4: An address byte that does not match is not acknowledged and changes neither buf_data nor irq. Every byte after it is ignored until the next START.
- R5: After a matched address with bit 0 = 0, each data byte is loaded into buf_data and acknowledged, under the same buffer and overflow condition as R3.
- R6: A byte that completes while buf_full is set, with no read pending, sets ovf. That byte is not acknowledged and buf_data is kept.
- R7: While ovf is set, no byte is acknowledged or loaded, even if the buffer is free. ovf is cleared only by a clr_ov pulse.
- R8: For every byte in an addressed transfer, acknowledged or not, irq is set at the falling edge of the 9th SCL pulse. irq is cleared only by a clr_irq pulse.
- R9: A rd_buf pulse leaves buf_full unchanged until the next acknowledge decision, at the 8th SCL falling edge of the next byte. At that decision the buffer counts as free, and buf_full is cleared unless a new byte is loaded.
- R10: While en is 0, the engine is idle, sda_oe stays 0, and neither START nor STOP is detected.
- R11: After a matched address with bit 0 = 1, the engine acknowledges the address and then ignores the bytes that follow until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable |
| own_addr | input | 7 | Own 7-bit target address |
| scl_in | input | 1 | SCL line as seen at the pin |
| sda_in | input | 1 | SDA line as seen at the pin |
| rd_buf | input | 1 | CPU read strobe for the holding register |
| clr_irq | input | 1 | CPU strobe that clears irq |
| clr_ov | input | 1 | CPU strobe that clears ovf |
| sda_oe | output | 1 | Drives SDA low when 1 (open-drain ACK) |
| buf_data | output | 8 | Holding register contents |
| buf_full | output | 1 | Holding register holds unread data |
| ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Sticky per-byte interrupt flag |
| rw_bit | output | 1 | Bit 0 of the last matched address byte |
| start_seen | output | 1 | Last bus condition was a START |
| stop_seen | output | 1 | Last bus condition was a STOP |

## Verification
The assertions assume that the CPU strobes are single-cycle pulses. They also assume that SCL and SDA change slowly compared with clk, so that every edge passes the synchronizer and is seen exactly once. The stimulus meets both assumptions. It holds each SCL phase for several clk cycles, changes SDA only while SCL is low (except to form START and STOP), and drives each strobe for exactly one cycle at a falling clock edge.

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-2:0] own_addr,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          rd_buf,
  input  logic          clr_irq,
  input  logic          clr_ov,
  output logic          sda_oe,
  output logic [DW-1:0] buf_data,
  output logic          buf_full,
  output logic          ovf,
  output logic          irq,
  output logic          rw_bit,
  output logic          start_seen,
  output logic          stop_seen
);
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [1:0] {IDLE, ADDR, DATA, ACKS} st_t;

  st_t            st;
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic           scl_d, sda_d;
  logic [DW-1:0]  sr;
  logic [CW-1:0]  cnt;
  logic           rd_pend, go_data;

  wire scl_s   = scl_sh[SYNC-1];
  wire sda_s   = sda_sh[SYNC-1];
  wire scl_r   = scl_s & ~scl_d;
  wire scl_f   = ~scl_s & scl_d;
  wire start_c = en & scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = en & scl_s & scl_d & ~sda_d & sda_s;
  wire hit     = sr[DW-1:1] == own_addr;
  wire free    = ~buf_full | rd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh     <= '1;
      sda_sh     <= '1;
      scl_d      <= 1'b1;
      sda_d      <= 1'b1;
      st         <= IDLE;
      sr         <= '0;
      cnt        <= '0;
      rd_pend    <= 1'b0;
      go_data    <= 1'b0;
      sda_oe     <= 1'b0;
      buf_data   <= '0;
      buf_full   <= 1'b0;
      ovf        <= 1'b0;
      irq        <= 1'b0;
      rw_bit     <= 1'b0;
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC-2:0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
      if (clr_irq) irq <= 1'b0;
      if (clr_ov)  ovf <= 1'b0;

      if (!en) begin
        st     <= IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        st         <= ADDR;
        cnt        <= '0;
        start_seen <= 1'b1;
        stop_seen  <= 1'b0;
        sda_oe     <= 1'b0;
      end else if (stop_c) begin
        st         <= IDLE;
        stop_seen  <= 1'b1;
        start_seen <= 1'b0;
        sda_oe     <= 1'b0;
      end else begin
        case (st)
          ADDR, DATA: begin
            if (scl_r && cnt < CW'(DW)) begin
              sr  <= {sr[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_f && cnt == CW'(DW)) begin
              cnt     <= '0;
              rd_pend <= 1'b0;
              if (rd_pend) buf_full <= 1'b0;
              if (st == ADDR && !hit) begin
                st <= IDLE;
              end else begin
                st <= ACKS;
                if (st == ADDR) begin
                  rw_bit  <= sr[0];
                  go_data <= ~sr[0];
                end else begin
                  go_data <= 1'b1;
                end
                if (free && !ovf) begin
                  buf_data <= sr;
                  buf_full <= 1'b1;
                  sda_oe   <= 1'b1;
                end else if (!free) begin
                  ovf <= 1'b1;
                end
              end
            end
          end
          ACKS: begin
            if (scl_f) begin
              sda_oe <= 1'b0;
              irq    <= 1'b1;
              st     <= go_data ? DATA : IDLE;
            end
          end
          default: st <= IDLE;
        endcase
      end

      if (rd_buf) rd_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          clr_irq,
  input logic          clr_ov,
  input logic          sda_oe,
  input logic [DW-1:0] buf_data,
  input logic          buf_full,
  input logic          ovf,
  input logic          irq,
  input logic          start_seen,
  input logic          stop_seen
);
  AST_ACK_NEEDS_NO_OV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !ovf); // R7
  AST_FULL_RISES_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> $rose(sda_oe)); // R3
  AST_BUF_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(buf_data) |-> $rose(sda_oe)); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_irq |=> irq); // R8
  AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr_ov |=> ovf); // R7
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sda_oe); // R10
  AST_COND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen)); // R2
endmodule

bind i2c_slave_rx i2c_slave_rx_chk #(.DW(DW)) u_chk (.*);

// File: tb/i2c_slave_rx_bench.sv
module i2c_slave_rx_bench;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1;
  logic [6:0] own_addr = 7'h2A;
  logic scl = 1'b1, m_sda = 1'b1;
  logic rd_buf = 1'b0, clr_irq = 1'b0, clr_ov = 1'b0;
  logic sda_oe, buf_full, ovf, irq, rw_bit, start_seen, stop_seen;
  logic [7:0] buf_data;
  wire sda_line = m_sda & ~sda_oe;

  int total = 0, bad = 0;
  bit done = 0;
  logic exp_q[$];
  string tag_q[$];
  logic obs_ack;
  event ack_ev;

  always #4 clk = ~clk;

  i2c_slave_rx u_i2c_slave_rx (
    .clk(clk), .rst_n(rst_n), .en(en), .own_addr(own_addr),
    .scl_in(scl), .sda_in(sda_line), .rd_buf(rd_buf), .clr_irq(clr_irq),
    .clr_ov(clr_ov), .sda_oe(sda_oe), .buf_data(buf_data), .buf_full(buf_full),
    .ovf(ovf), .irq(irq), .rw_bit(rw_bit), .start_seen(start_seen),
    .stop_seen(stop_seen));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0; w(2);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; w(Q); scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(Q); scl = 1'b1; w(Q); m_sda = 1'b1; w(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_nack, input string tag);
    exp_q.push_back(exp_nack);
    tag_q.push_back(tag);
    if (scl) begin scl = 1'b0; w(Q); end
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(Q); scl = 1'b1; w(2 * Q); scl = 1'b0; w(Q);
    end
    m_sda = 1'b1; w(Q); scl = 1'b1; w(Q);
    obs_ack = sda_line;
    -> ack_ev;
    w(Q); scl = 1'b0; w(Q + 6);
  endtask

  initial begin
    forever begin
      @(ack_ev);
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty actual=%0b expected=none", obs_ack);
      end else begin
        logic e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (obs_ack !== e) begin
          bad++;
          $display("FAIL %s ack slot actual=%0b expected=%0b", t, obs_ack, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    w(3); rst_n = 1'b1; w(3);
    chk("R1 oe", sda_oe, 0); chk("R1 full", buf_full, 0); chk("R1 ovf", ovf, 0);
    chk("R1 irq", irq, 0); chk("R1 rw", rw_bit, 0);
    chk("R1 start", start_seen, 0); chk("R1 stop", stop_seen, 0);

    bus_start();
    chk("R2 start", start_seen, 1); chk("R2 stop", stop_seen, 0);
    send_byte(8'h54, 1'b0, "R3");
    chk("R3 buf", buf_data, 8'h54); chk("R3 full", buf_full, 1);
    chk("R3 rw", rw_bit, 0); chk("R8 irq", irq, 1);
    pulse(rd_buf);
    chk("R9 full held", buf_full, 1);
    pulse(clr_irq);
    chk("R8 clr", irq, 0);

    send_byte(8'hA5, 1'b0, "R5");
    chk("R5 buf", buf_data, 8'hA5); chk("R9 full", buf_full, 1); chk("R8 irq2", irq, 1);
    pulse(clr_irq);

    send_byte(8'h3C, 1'b1, "R6");
    chk("R6 ovf", ovf, 1); chk("R6 buf", buf_data, 8'hA5);
    chk("R6 full", buf_full, 1); chk("R8 nack irq", irq, 1);
    pulse(clr_irq);

    pulse(rd_buf);
    send_byte(8'h11, 1'b1, "R7");
    chk("R7 ovf", ovf, 1); chk("R7 buf", buf_data, 8'hA5); chk("R9 release", buf_full, 0);
    pulse(clr_ov);
    chk("R7 clr", ovf, 0);
    send_byte(8'h77, 1'b0, "R7 after clr");
    chk("R7 buf2", buf_data, 8'h77); chk("R7 full2", buf_full, 1);

    bus_stop();
    chk("R2 stop set", stop_seen, 1); chk("R2 start clr", start_seen, 0);
    pulse(clr_irq);
    send_byte(8'hFF, 1'b1, "R2 idle");
    chk("R2 idle buf", buf_data, 8'h77); chk("R2 idle irq", irq, 0);

    pulse(rd_buf);
    bus_start();
    send_byte(8'h20, 1'b1, "R4");
    chk("R4 irq", irq, 0); chk("R4 buf", buf_data, 8'h77); chk("R9 slot free", buf_full, 0);
    send_byte(8'h54, 1'b1, "R4 ignored");
    chk("R4 buf2", buf_data, 8'h77); chk("R4 full", buf_full, 0);

    bus_start();
    send_byte(8'h55, 1'b0, "R11");
    chk("R11 rw", rw_bit, 1); chk("R11 buf", buf_data, 8'h55); chk("R11 full", buf_full, 1);
    pulse(clr_irq);
    send_byte(8'h00, 1'b1, "R11 ignored");
    chk("R11 ovf", ovf, 0); chk("R11 irq", irq, 0); chk("R11 buf2", buf_data, 8'h55);

    en = 1'b0;
    pulse(rd_buf);
    bus_stop();
    chk("R10 stop", stop_seen, 0);
    bus_start();
    send_byte(8'h54, 1'b1, "R10");
    chk("R10 buf", buf_data, 8'h55); chk("R10 irq", irq, 0); chk("R10 oe", sda_oe, 0);

    w(4);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule